// File: doc/BRIEF.md
# Memory-to-Memory Stack Machine Core

This core is a multi-cycle processor for a small word-addressed instruction set in which arithmetic operands and results are memory locations rather than registers. Each location is named by a general register plus a signed offset. One addend of the three-operand add is always the word on top of the stack, which is the word addressed by register 1. The core holds eight 32-bit general registers and a program counter. It also keeps two special 32-bit registers for the upper and lower halves of a product, which are retained for later multiply support.

A single synchronous memory port with one cycle of read latency serves both instruction fetch and data access. Every instruction therefore runs as a short sequence of states, one memory access per state. Each instruction starts by fetching the word at the program counter and incrementing the counter before anything else happens. An opcode outside the supported set stops the core and raises `halt`, which stays high until reset.

Top module: `mtm_stack_core`

## Requirements
- R1: While reset is active and after it is released: `halt` is 0, `hi` and `lo` are 0, all general registers and the program counter are 0, and the first fetch presents address 0. `hi` and `lo` stay 0 throughout operation.
- R2: The core fetches the word at PC and sets PC to PC+1 before it executes that word. The jump (opcode 5) sets PC to the already incremented PC plus the sign-extended 16-bit offset, modulo 2^15. The word after a jump with offset +1 therefore never executes.
- R3: The opcode is in bits 31:26, with ADD=1, ADDI=2, SRI=3, LWR=4 and JMP=5. Field A is bits 25:23, field B is bits 22:20, field C is bits 19:17, and the 16-bit offset or immediate is bits 15:0, sign-extended. Measured from the fetch state, ADD takes 5 cycles, ADDI and LWR take 4, and SRI, JMP and an unknown opcode take 3.
- R4: ADD writes mem[GPR[1]] + mem[GPR[B]+GPR[C]] to mem[GPR[A]+offset]. Both operands are read before the result is written.
- R5: ADDI reads mem[GPR[A]+o], adds i, and writes the result back to the same word. Here o is bits 22:12 sign-extended and i is bits 11:0 sign-extended. It asserts `mem_we` for exactly one cycle.
- R6: SRI sets GPR[A] to GPR[A] minus the sign-extended 16-bit immediate.
- R7: LWR loads mem[GPR[B]+offset] into GPR[A].
- R8: Every effective address is the low 15 bits of the 32-bit register-plus-offset sum, so addresses wrap within 32768 words.
- R9: Any opcode not listed in R3, including 0, raises `halt` at the end of its execute cycle. After that `halt` stays 1 and `mem_we` stays 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 15 | Word address for fetch, read or write |
| mem_we | output | 1 | Write strobe for the current address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| halt | output | 1 | Core stopped on an unknown opcode |
| hi | output | 32 | Upper product register |
| lo | output | 32 | Lower product register |

## Verification
On the single memory port, an ADD write-back is followed directly by the next instruction fetch. An ADD can therefore rewrite the instruction word that executes immediately after it, and it can also write its result onto the same top-of-stack word it has just read as an operand. A directed program makes an ADD produce the encoding of a new SRI in the next instruction slot, and the run length shows whether the rewritten word executed. A second program writes a sum onto the top of stack and then uses it in a following ADD. Random programs mix jumps over garbage words with stack adjustments. The whole memory image and the cycle count are compared with an instruction-level model in the bench.

// File: rtl/mtm_stack_core.sv
module mtm_stack_core #(
  parameter int DW = 32,
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halt,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] lo
);
  localparam int NREG = 8;
  localparam int TOS  = 1;
  localparam logic [5:0] OP_ADD  = 6'd1;
  localparam logic [5:0] OP_ADDI = 6'd2;
  localparam logic [5:0] OP_SRI  = 6'd3;
  localparam logic [5:0] OP_LWR  = 6'd4;
  localparam logic [5:0] OP_JMP  = 6'd5;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_EX, S_RD2, S_WB, S_LD, S_HALT} st_t;

  st_t           state_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ir_q, tmp_q, hi_q, lo_q;
  logic [DW-1:0] gpr_q [NREG];

  logic [5:0]    op;
  logic [2:0]    fa, fb, fc;
  logic [DW-1:0] imm_s, addi_off, addi_inc, dst_off;
  logic [AW-1:0] tos_addr, src_addr, dst_addr, ld_addr;

  assign op       = ir_q[31:26];
  assign fa       = ir_q[25:23];
  assign fb       = ir_q[22:20];
  assign fc       = ir_q[19:17];
  assign imm_s    = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
  assign addi_off = {{(DW-11){ir_q[22]}}, ir_q[22:12]};
  assign addi_inc = {{(DW-12){ir_q[11]}}, ir_q[11:0]};
  assign dst_off  = (op == OP_ADDI) ? addi_off : imm_s;

  assign tos_addr = gpr_q[TOS][AW-1:0];
  assign src_addr = AW'(gpr_q[fb] + gpr_q[fc]);
  assign dst_addr = AW'(gpr_q[fa] + dst_off);
  assign ld_addr  = AW'(gpr_q[fb] + imm_s);

  always_comb begin
    mem_addr = pc_q;
    case (state_q)
      S_EX: begin
        if (op == OP_ADD)       mem_addr = tos_addr;
        else if (op == OP_ADDI) mem_addr = dst_addr;
        else if (op == OP_LWR)  mem_addr = ld_addr;
      end
      S_RD2:   mem_addr = src_addr;
      S_WB:    mem_addr = dst_addr;
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_we    = (state_q == S_WB);
  assign mem_wdata = tmp_q + mem_rdata;
  assign halt      = (state_q == S_HALT);
  assign hi        = hi_q;
  assign lo        = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      tmp_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      for (int i = 0; i < NREG; i++) gpr_q[i] <= '0;
    end else begin
      case (state_q)
        S_FETCH: state_q <= S_DEC;
        S_DEC: begin
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + 1'b1;
          state_q <= S_EX;
        end
        S_EX: begin
          case (op)
            OP_ADD:  state_q <= S_RD2;
            OP_ADDI: begin
              tmp_q   <= addi_inc;
              state_q <= S_WB;
            end
            OP_SRI: begin
              gpr_q[fa] <= gpr_q[fa] - imm_s;
              state_q   <= S_FETCH;
            end
            OP_LWR:  state_q <= S_LD;
            OP_JMP: begin
              pc_q    <= pc_q + imm_s[AW-1:0];
              state_q <= S_FETCH;
            end
            default: state_q <= S_HALT;
          endcase
        end
        S_RD2: begin
          tmp_q   <= mem_rdata;
          state_q <= S_WB;
        end
        S_WB: state_q <= S_FETCH;
        S_LD: begin
          gpr_q[fa] <= mem_rdata;
          state_q   <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mtm_stack_core_chk.sv
module mtm_stack_core_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt,
  input logic          mem_we,
  input logic [2:0]    state,
  input logic [AW-1:0] pc
);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_we);

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |=> (pc == AW'($past(pc) + 1'b1)));

  assert_fetch_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (state == 3'd0));
endmodule

bind mtm_stack_core mtm_stack_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .mem_we(mem_we),
  .state(state_q), .pc(pc_q)
);

// File: tb/mtm_stack_core_bench.sv
`timescale 1ns/1ps
module mtm_stack_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        halt;
  logic [31:0] hi, lo;

  mtm_stack_core u_mtm_stack_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halt(halt), .hi(hi), .lo(lo)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] mem     [4096];
  logic [31:0] ref_mem [4096];
  logic [31:0] img     [4096];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [2:0] a, b, c,
                                      input logic [15:0] im);
    return {op, a, b, c, 1'b0, im};
  endfunction

  function automatic logic [31:0] enc_addi(input logic [2:0] r, input logic [10:0] o,
                                           input logic [11:0] i);
    return {6'd2, r, o, i};
  endfunction

  task automatic ref_run(output int cyc);
    logic [14:0] pc;
    logic [31:0] g [8];
    logic [31:0] w, im, ad, v;
    pc = '0;
    cyc = 0;
    for (int k = 0; k < 8; k++) g[k] = '0;
    for (int n = 0; n < 1000; n++) begin
      w  = ref_mem[pc[11:0]];
      pc = pc + 1'b1;
      im = {{16{w[15]}}, w[15:0]};
      case (w[31:26])
        6'd1: begin
          ad = g[w[22:20]] + g[w[19:17]];
          v  = ref_mem[g[1][11:0]] + ref_mem[ad[11:0]];
          ad = g[w[25:23]] + im;
          ref_mem[ad[11:0]] = v;
          cyc += 5;
        end
        6'd2: begin
          ad = g[w[25:23]] + {{21{w[22]}}, w[22:12]};
          ref_mem[ad[11:0]] = ref_mem[ad[11:0]] + {{20{w[11]}}, w[11:0]};
          cyc += 4;
        end
        6'd3: begin g[w[25:23]] = g[w[25:23]] - im; cyc += 3; end
        6'd4: begin
          ad = g[w[22:20]] + im;
          g[w[25:23]] = ref_mem[ad[11:0]];
          cyc += 4;
        end
        6'd5: begin pc = pc + im[14:0]; cyc += 3; end
        default: begin cyc += 3; return; end
      endcase
    end
    cyc = -1;
  endtask

  task automatic run_prog(input string tag, output int cyc);
    logic [14:0] ca;
    logic        cw;
    logic [31:0] cd;
    int cnt, exp_cyc, mm, bad;
    bit got;
    for (int i = 0; i < 4096; i++) begin mem[i] = img[i]; ref_mem[i] = img[i]; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ca = mem_addr; cw = mem_we; cd = mem_wdata;
    chk(ca == 15'd0 && !halt, "R1", ca, 0);
    cnt = 0; got = 1'b0;
    while (cnt < 3000 && !got) begin
      @(posedge clk);
      mem_rdata <= mem[ca[11:0]];
      if (cw) mem[ca[11:0]] = cd;
      @(negedge clk);
      cnt++;
      if (halt) got = 1'b1;
      ca = mem_addr; cw = mem_we; cd = mem_wdata;
    end
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      mem_rdata <= mem[ca[11:0]];
      if (cw) mem[ca[11:0]] = cd;
      @(negedge clk);
      if (!halt || mem_we) bad++;
      ca = mem_addr; cw = mem_we; cd = mem_wdata;
    end
    ref_run(exp_cyc);
    chk(got && cnt == exp_cyc, {tag, " cycles"}, cnt, exp_cyc);
    mm = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) mm++;
    chk(mm == 0, {tag, " memory mismatches"}, mm, 0);
    chk(bad == 0, "R9 halt sticky and silent", bad, 0);
    chk(hi == 0 && lo == 0, "R1 hi/lo", hi | lo, 0);
    cyc = cnt;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 4096; i++) img[i] = $urandom;
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 watchdog actual=running expected=halted");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc;
    int idx;
    logic [2:0] rsel [6];
    rsel[0] = 3'd0; rsel[1] = 3'd2; rsel[2] = 3'd3;
    rsel[3] = 3'd4; rsel[4] = 3'd5; rsel[5] = 3'd6;
    void'($urandom(32'd2468));

    repeat (2) @(negedge clk);
    chk(!halt && !mem_we && mem_addr == 0 && hi == 0 && lo == 0, "R1 reset state",
        {halt, mem_we, mem_addr}, 0);

    // R4: ADD rewrites the instruction that follows it
    fill_rand();
    img[0] = enc(6'd3, 3'd1, 3'd0, 3'd0, 16'd1);
    img[1] = enc(6'd1, 3'd7, 3'd7, 3'd7, 16'd2);
    img[2] = 32'h0;
    img[3] = enc(6'd63, 3'd0, 3'd0, 3'd0, 16'd0);
    img[4095] = enc(6'd3, 3'd3, 3'd0, 3'd0, 16'd5) - img[0];
    run_prog("R4 self-modify", cyc);
    chk(cyc == 14, "R4 rewritten word executed", cyc, 14);
    chk(mem[2] == enc(6'd3, 3'd3, 3'd0, 3'd0, 16'd5), "R4 rewritten word", mem[2],
        enc(6'd3, 3'd3, 3'd0, 3'd0, 16'd5));

    // R2: jump over a word that would modify memory
    fill_rand();
    img[0] = enc(6'd5, 3'd0, 3'd0, 3'd0, 16'd1);
    img[1] = enc_addi(3'd0, 11'd100, 12'd5);
    img[2] = enc_addi(3'd0, 11'd100, 12'd7);
    img[3] = 32'h0;
    img[100] = 32'd1000;
    run_prog("R2 jump", cyc);
    chk(mem[100] == 32'd1007, "R2 skipped word", mem[100], 1007);
    chk(cyc == 10, "R3 jump/addi timing", cyc, 10);

    // R7 and R8: load a base near the top, address wraps
    fill_rand();
    img[0] = enc(6'd4, 3'd2, 3'd7, 3'd0, 16'd4000);
    img[1] = enc_addi(3'd2, 11'd10, 12'd1);
    img[2] = enc(6'd6, 3'd0, 3'd0, 3'd0, 16'd0);
    img[4000] = 32'd32767;
    img[9] = 32'd500;
    run_prog("R8 wrap", cyc);
    chk(mem[9] == 32'd501, "R8 wrapped address", mem[9], 501);
    chk(cyc == 11, "R7 load timing", cyc, 11);

    // R4: result written onto the top of stack, then reused
    fill_rand();
    img[0] = enc(6'd3, 3'd1, 3'd0, 3'd0, 16'd2);
    img[1] = enc(6'd4, 3'd2, 3'd7, 3'd0, 16'd200);
    img[2] = enc(6'd1, 3'd1, 3'd2, 3'd7, 16'd0);
    img[3] = enc(6'd1, 3'd1, 3'd2, 3'd7, 16'hFFFB);
    img[4] = 32'h0;
    img[200] = 32'd150;
    img[150] = 32'd32;
    img[4094] = 32'd10;
    run_prog("R4 top of stack", cyc);
    chk(mem[4094] == 32'd42, "R4 sum onto TOS", mem[4094], 42);
    chk(mem[4089] == 32'd74, "R4 negative offset", mem[4089], 74);
    chk(cyc == 20, "R3 add timing", cyc, 20);

    // R6: SRI with a negative immediate increments the register
    fill_rand();
    img[0] = enc(6'd3, 3'd3, 3'd0, 3'd0, 16'hFFFD);
    img[1] = enc_addi(3'd3, 11'd0, 12'd9);
    img[2] = enc(6'd40, 3'd0, 3'd0, 3'd0, 16'd0);
    img[3] = 32'd40;
    run_prog("R6 sri", cyc);
    chk(mem[3] == 32'd49, "R6 register after SRI", mem[3], 49);
    chk(cyc == 10, "R5 addi timing", cyc, 10);

    // R3/R4/R5: constrained random programs
    for (int r = 0; r < 25; r++) begin
      fill_rand();
      for (int j = 0; j < 16; j++) img[3900 + j] = 32'd2048 + $urandom_range(0, 800);
      idx = 0;
      img[idx++] = enc(6'd3, 3'd1, 3'd0, 3'd0, 16'(1000 + $urandom_range(0, 50)));
      for (int j = 0; j < 6; j++)
        img[idx++] = enc(6'd4, rsel[j], 3'd7, 3'd0, 16'(3900 + $urandom_range(0, 15)));
      for (int j = 0; j < 14; j++) begin
        case ($urandom_range(0, 9))
          0, 1, 2, 3: img[idx++] = enc(6'd1, 3'($urandom_range(0, 6)), 3'($urandom_range(0, 7)),
                                       3'($urandom_range(0, 7)), 16'($urandom_range(0, 200)));
          4, 5, 6: img[idx++] = enc_addi(3'($urandom_range(0, 6)), 11'($urandom_range(0, 200)),
                                         12'($urandom));
          7: img[idx++] = enc(6'd3, 3'($urandom_range(0, 6)), 3'd0, 3'd0,
                              16'($urandom_range(0, 7)));
          8: begin
            img[idx++] = enc(6'd5, 3'd0, 3'd0, 3'd0, 16'd1);
            img[idx++] = $urandom;
          end
          default: img[idx++] = enc(6'd4, rsel[$urandom_range(0, 5)], 3'd7, 3'd0,
                                    16'(3900 + $urandom_range(0, 15)));
        endcase
      end
      img[idx] = ($urandom_range(0, 3) == 0) ? 32'h0
               : enc(6'(6 + $urandom_range(0, 57)), 3'd0, 3'd0, 3'd0, 16'd0);
      run_prog("R3 random", cyc);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule